// File: doc/BRIEF.md
# Byte-Wide Link Port Receiver

This block receives a stream of bytes from an external sender over an 8-bit data bus. The sender supplies its own strobe clock, which is unrelated to the core clock. Every rising edge of that incoming clock carries one byte. The block gathers four consecutive bytes into a 32-bit word, with the first byte in the least significant position. It holds the finished word in a staging buffer in the link clock domain, then hands the word over to a core-side holding buffer through a toggle handshake with two-flop synchronizers.

The core sees a word-available flag and the held word. It frees the holding buffer with a one-cycle read strobe. The block drives an acknowledge line back to the sender. The line drops when both buffers are occupied, and it rises again once a core read lets the staged word move forward. Some words cannot be staged because the staging buffer is still occupied. Each such word is thrown away and raises a sticky overflow flag, which only an explicit clear input resets.

The sender must leave a short idle gap between words. The gap must be long enough for the core side to take the previous word: about three core cycles. Words sent back to back without that gap are only safe when the link clock is slower than this handshake.

Top module: `lrx_receiver`

## Requirements
- R1: After reset, lnkAck is 1, and wordAvail, extPending and overflowErr are 0.
- R2: One byte is captured on each rising edge of lnkClk. Four bytes form one word: the first byte goes to bits 7:0, the second to 15:8, the third to 23:16 and the fourth to 31:24.
- R3: A completed word goes into the staging buffer when that buffer is free. It moves to the holding buffer as soon as the holding buffer is empty. extPending is 1 while a staged word is waiting to move.
- R4: wordAvail is 1 while the holding buffer holds an unread word, and rdData shows that word. rdEn while wordAvail is 1 frees the buffer. rdEn while wordAvail is 0 has no effect.
- R5: lnkAck goes to 0 within one core cycle once a word is staged while the holding buffer is full. It returns to 1 after a read lets the staged word move.
- R6: A word completed while the staging buffer is still occupied is discarded and sets overflowErr. Words already buffered are unaffected.
- R7: overflowErr stays at 1 until clrOverflow is pulsed, which returns it to 0.
- R8: Reception is correct with a link clock faster than the core clock and with one much slower than it.
- R9: Words reach the core in the order they were received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| lnkClk | input | 1 | Incoming link strobe clock, one byte per rising edge |
| lnkData | input | 8 | Link data bus |
| lnkAck | output | 1 | Flow control to the sender, 1 means it may continue |
| rdEn | input | 1 | Core read strobe, frees the holding buffer |
| rdData | output | 32 | Word in the holding buffer |
| wordAvail | output | 1 | Holding buffer contains an unread word |
| extPending | output | 1 | Staging buffer holds a word not yet moved to the core |
| clrOverflow | input | 1 | Clears the sticky overflow flag |
| overflowErr | output | 1 | Sticky overflow flag |

## Verification
The hardest state to reach is an overflow. To get there, the core must hold back its reads, the sender must ignore a low acknowledge, and a further full word must arrive. A further difficulty is that the link-side synchronizer only advances while the sender clocks bytes. The bench therefore stacks two words without reading, which fills both buffers. It checks that the acknowledge is low, then clocks in a third word. It then drains the buffers to show that only the first two words survive. The flag is checked again after a wait and after a clear. A separate directed case repeats two-word traffic with a link clock faster than the core clock and with a very slow one.

// File: rtl/lrx_pkg.sv
`timescale 1ns/1ps
package lrx_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadExt;   // link domain: latch assembled word into staging buffer
    logic loadInt;   // core domain: copy staging buffer into holding buffer
  } lrxStrobe_t;
endpackage

// File: rtl/lrx_sync2.sv
`timescale 1ns/1ps
module lrx_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic dOut
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= dIn;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], dIn};
      end
    end
  endgenerate

  assign dOut = chain[STAGES-1];
endmodule

// File: rtl/lrx_datapath.sv
`timescale 1ns/1ps
module lrx_datapath
  import lrx_pkg::*;
#(
  parameter int BYTE_W         = 8,
  parameter int BYTES_PER_WORD = 4,
  localparam int WORD_W        = BYTE_W * BYTES_PER_WORD,
  localparam int CNT_W         = $clog2(BYTES_PER_WORD)
) (
  input  logic              lnkClk,
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] lnkData,
  input  logic [CNT_W-1:0]  byteIdx,
  input  lrxStrobe_t        stb,
  output logic [WORD_W-1:0] rdData
);
  logic [WORD_W-1:0] asmReg;
  logic [WORD_W-1:0] assembled;
  logic [WORD_W-1:0] extBuf;
  logic [WORD_W-1:0] intBuf;

  // current byte merged into its lane of the word being built
  always_comb begin
    assembled = asmReg;
    assembled[byteIdx*BYTE_W +: BYTE_W] = lnkData;
  end

  always_ff @(posedge lnkClk or negedge rstN) begin
    if (!rstN) begin
      asmReg <= '0;
      extBuf <= '0;
    end else begin
      asmReg <= assembled;
      if (stb.loadExt) extBuf <= assembled;
    end
  end

  // extBuf is held stable by the handshake while it is copied here
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            intBuf <= '0;
    else if (stb.loadInt) intBuf <= extBuf;
  end

  assign rdData = intBuf;

  // R2: the first byte of a staged word is the one captured earliest
  a_r2_first_lane: assert property (@(posedge lnkClk) disable iff (!rstN)
    stb.loadExt |=> extBuf[BYTE_W-1:0] == $past(asmReg[BYTE_W-1:0]));

  // R4: an occupied holding buffer is only replaced by a new transfer
  a_r4_int_stable: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadInt |=> $stable(rdData));
endmodule

// File: rtl/lrx_control.sv
`timescale 1ns/1ps
module lrx_control
  import lrx_pkg::*;
#(
  parameter int BYTES_PER_WORD = 4,
  parameter int SYNC_STAGES    = 2,
  localparam int CNT_W         = $clog2(BYTES_PER_WORD)
) (
  input  logic             lnkClk,
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdEn,
  input  logic             clrOvf,
  output logic [CNT_W-1:0] byteIdx,
  output lrxStrobe_t       stb,
  output logic             lnkAck,
  output logic             wordAvail,
  output logic             extPending,
  output logic             overflowErr
);
  // ---------------- link clock domain ----------------
  logic [CNT_W-1:0] byteCnt;
  logic             reqTog;
  logic             ovfTog;
  logic             ackSyncL;
  logic             lastByte;
  logic             extFree;
  logic             dropWord;
  logic             loadExt;

  // ---------------- core clock domain ----------------
  logic ackTog;
  logic reqSyncC;
  logic ovfSyncC;
  logic ovfSeen;
  logic ovfEvent;
  logic intFull;
  logic pending;
  logic loadInt;

  assign lastByte = (byteCnt == CNT_W'(BYTES_PER_WORD - 1));
  assign extFree  = (reqTog == ackSyncL);
  assign loadExt  = lastByte && extFree;
  assign dropWord = lastByte && !extFree;

  always_ff @(posedge lnkClk or negedge rstN) begin
    if (!rstN) begin
      byteCnt <= '0;
      reqTog  <= 1'b0;
      ovfTog  <= 1'b0;
    end else begin
      byteCnt <= lastByte ? '0 : byteCnt + 1'b1;
      if (loadExt)  reqTog <= ~reqTog;
      if (dropWord) ovfTog <= ~ovfTog;
    end
  end

  lrx_sync2 #(.STAGES(SYNC_STAGES)) u_ackSync (
    .clk(lnkClk), .rstN(rstN), .dIn(ackTog), .dOut(ackSyncL));
  lrx_sync2 #(.STAGES(SYNC_STAGES)) u_reqSync (
    .clk(clk), .rstN(rstN), .dIn(reqTog), .dOut(reqSyncC));
  lrx_sync2 #(.STAGES(SYNC_STAGES)) u_ovfSync (
    .clk(clk), .rstN(rstN), .dIn(ovfTog), .dOut(ovfSyncC));

  assign pending  = (reqSyncC != ackTog);
  assign loadInt  = pending && !intFull;
  assign ovfEvent = (ovfSyncC != ovfSeen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackTog      <= 1'b0;
      intFull     <= 1'b0;
      ovfSeen     <= 1'b0;
      overflowErr <= 1'b0;
      lnkAck      <= 1'b1;
    end else begin
      if (loadInt) begin
        ackTog  <= ~ackTog;
        intFull <= 1'b1;
      end else if (rdEn) begin
        intFull <= 1'b0;
      end
      ovfSeen <= ovfSyncC;
      if (ovfEvent)    overflowErr <= 1'b1;
      else if (clrOvf) overflowErr <= 1'b0;
      lnkAck <= !(pending && intFull);
    end
  end

  always_comb begin
    stb         = '0;
    stb.loadExt = loadExt;
    stb.loadInt = loadInt;
  end

  assign byteIdx    = byteCnt;
  assign wordAvail  = intFull;
  assign extPending = pending;

  // R2: the byte counter wraps after the last lane
  a_r2_wrap: assert property (@(posedge lnkClk) disable iff (!rstN)
    lastByte |=> byteCnt == '0);

  // R3: one transfer fills the holding buffer, so the next cycle cannot transfer
  a_r3_single_move: assert property (@(posedge clk) disable iff (!rstN)
    loadInt |=> !loadInt && intFull);

  // R4: an unread word stays until the core reads it
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    intFull && !rdEn |=> intFull);

  // R5: both buffers occupied drops the acknowledge
  a_r5_ack_low: assert property (@(posedge clk) disable iff (!rstN)
    pending && intFull |=> !lnkAck);

  // R5: with nothing staged the sender is allowed to continue
  a_r5_ack_high: assert property (@(posedge clk) disable iff (!rstN)
    !pending |=> lnkAck);

  // R7: overflow flag is sticky
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflowErr && !clrOvf |=> overflowErr);

  // R7: a clear with no new overflow event empties the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
    clrOvf && !ovfEvent |=> !overflowErr);
endmodule

// File: rtl/lrx_receiver.sv
`timescale 1ns/1ps
module lrx_receiver
  import lrx_pkg::*;
#(
  parameter int BYTE_W         = 8,
  parameter int BYTES_PER_WORD = 4,
  parameter int SYNC_STAGES    = 2,
  localparam int WORD_W        = BYTE_W * BYTES_PER_WORD,
  localparam int CNT_W         = $clog2(BYTES_PER_WORD)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lnkClk,
  input  logic [BYTE_W-1:0] lnkData,
  output logic              lnkAck,
  input  logic              rdEn,
  output logic [WORD_W-1:0] rdData,
  output logic              wordAvail,
  output logic              extPending,
  input  logic              clrOverflow,
  output logic              overflowErr
);
  lrxStrobe_t       stb;
  logic [CNT_W-1:0] byteIdx;

  lrx_control #(
    .BYTES_PER_WORD(BYTES_PER_WORD),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .lnkClk(lnkClk), .clk(clk), .rstN(rstN),
    .rdEn(rdEn), .clrOvf(clrOverflow),
    .byteIdx(byteIdx), .stb(stb),
    .lnkAck(lnkAck), .wordAvail(wordAvail),
    .extPending(extPending), .overflowErr(overflowErr)
  );

  lrx_datapath #(
    .BYTE_W(BYTE_W),
    .BYTES_PER_WORD(BYTES_PER_WORD)
  ) u_dp (
    .lnkClk(lnkClk), .clk(clk), .rstN(rstN),
    .lnkData(lnkData), .byteIdx(byteIdx), .stb(stb),
    .rdData(rdData)
  );
endmodule

// File: tb/lrx_receiver_bench.sv
`timescale 1ns/1ps
module lrx_receiver_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lnkClk = 1'b0;
  logic [7:0]  lnkData = '0;
  logic        lnkAck;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic        wordAvail;
  logic        extPending;
  logic        clrOverflow = 1'b0;
  logic        overflowErr;

  int nChk = 0;
  int nErr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lrx_receiver u_lrx_receiver (
    .clk(clk), .rstN(rstN), .lnkClk(lnkClk), .lnkData(lnkData),
    .lnkAck(lnkAck), .rdEn(rdEn), .rdData(rdData), .wordAvail(wordAvail),
    .extPending(extPending), .clrOverflow(clrOverflow), .overflowErr(overflowErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b, input int halfNs);
    lnkData = b;
    #(halfNs);
    lnkClk = 1'b1;
    #(halfNs);
    lnkClk = 1'b0;
  endtask

  task automatic sendWord(input logic [31:0] w, input int halfNs);
    for (int i = 0; i < 4; i++) sendByte(w[i*8 +: 8], halfNs);
  endtask

  task automatic readWord(input string req, input logic [31:0] exp);
    @(negedge clk);
    chk({req, " avail before read"}, {31'b0, wordAvail}, 32'd1);
    chk({req, " word value"}, rdData, exp);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ack", {31'b0, lnkAck}, 32'd1);
    chk("R1 wordAvail", {31'b0, wordAvail}, 32'd0);
    chk("R1 extPending", {31'b0, extPending}, 32'd0);
    chk("R1 overflowErr", {31'b0, overflowErr}, 32'd0);
  endtask

  task automatic t_empty_read();
    @(negedge clk); rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
    settle();
    chk("R4 empty read avail", {31'b0, wordAvail}, 32'd0);
    chk("R4 empty read ack", {31'b0, lnkAck}, 32'd1);
  endtask

  task automatic t_single();
    sendByte(8'hA1, 13); sendByte(8'hB2, 13);
    sendByte(8'hC3, 13); sendByte(8'hD4, 13);
    settle();
    chk("R3 staged word moved", {31'b0, extPending}, 32'd0);
    readWord("R2 lsb first", 32'hD4C3B2A1);
    settle();
    chk("R4 freed after read", {31'b0, wordAvail}, 32'd0);
  endtask

  task automatic t_backpressure();
    sendWord(32'h1111_0001, 13); settle();
    sendWord(32'h2222_0002, 13); settle();
    chk("R3 second word staged", {31'b0, extPending}, 32'd1);
    chk("R5 ack low when both full", {31'b0, lnkAck}, 32'd0);
    chk("R4 first word shown", rdData, 32'h1111_0001);
    readWord("R9 first out", 32'h1111_0001);
    settle();
    chk("R5 ack high after read", {31'b0, lnkAck}, 32'd1);
    chk("R3 staged word moved", {31'b0, extPending}, 32'd0);
    readWord("R9 second out", 32'h2222_0002);
    settle();
    chk("R4 empty again", {31'b0, wordAvail}, 32'd0);
  endtask

  task automatic t_overflow();
    sendWord(32'h3333_0003, 13); settle();
    sendWord(32'h4444_0004, 13); settle();
    chk("R6 no overflow yet", {31'b0, overflowErr}, 32'd0);
    sendWord(32'h5555_0005, 13); settle();
    chk("R6 overflow set", {31'b0, overflowErr}, 32'd1);
    chk("R6 staged word kept", {31'b0, extPending}, 32'd1);
    readWord("R6 older word intact", 32'h3333_0003);
    settle();
    readWord("R6 staged word intact", 32'h4444_0004);
    settle();
    chk("R6 dropped word absent", {31'b0, wordAvail}, 32'd0);
    repeat (30) @(negedge clk);
    chk("R7 flag sticky", {31'b0, overflowErr}, 32'd1);
    clrOverflow = 1'b1;
    @(negedge clk); clrOverflow = 1'b0;
    @(negedge clk);
    chk("R7 flag cleared", {31'b0, overflowErr}, 32'd0);
  endtask

  task automatic t_rates();
    // link clock faster than the core clock
    sendWord(32'h6666_0006, 4); #100;
    sendWord(32'h7777_0007, 4); settle();
    readWord("R8 fast first", 32'h6666_0006); settle();
    readWord("R8 fast second", 32'h7777_0007); settle();
    // link clock much slower than the core clock
    sendWord(32'h8888_0008, 47); #100;
    sendWord(32'h9999_0009, 47); settle();
    readWord("R8 slow first", 32'h8888_0008); settle();
    readWord("R8 slow second", 32'h9999_0009); settle();
    chk("R8 no overflow", {31'b0, overflowErr}, 32'd0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty_read();
    t_single();
    t_backpressure();
    t_overflow();
    t_rates();
    finishRun();
  end

  initial begin
    #1000000;
    nChk++;
    nErr++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end
endmodule